// File: doc/BRIEF.md
# Multi-DAC Serial Write Controller

This host-side block sends 16-bit conversion codes to a group of serial-input DACs. All of the DACs share a single serial clock line and a single data line. Each DAC has its own active-low select. A client hands over a channel address, a code and a load-mode bit through a valid/ready handshake. The block decodes the address into exactly one select line and shifts the frame out MSB first. The serial clock toggles only while a select is low, so idle converters see no digital activity.

The block offers two ways to update the DAC register. In immediate mode the load strobe is held low for the whole frame, so the DAC register takes the new value when its select rises. In deferred mode the load strobe stays high through the frame and is pulsed low afterwards, with a programmed setup gap and a programmed pulse width. A minimum select-high interval is always observed before the next frame begins.

Codes narrower than the frame are left-justified, and the spare low bits are filled with zeros. A request whose address has no channel behind it is still accepted, but it produces no frame and raises a one-cycle error flag. All timing is counted in system-clock cycles set by parameters.

Top module: `mdac_wr_ctrl`

## Requirements
- R1: While a frame is in progress, only the select line whose index equals the accepted address is low. At no time is more than one select line low.
- R2: Each frame carries exactly 16 rising serial-clock edges. The data line gives the frame MSB first, changes only while the serial clock is low, and is stable at each rising edge.
- R3: The serial clock rests low and does not toggle whenever no select line is low.
- R4: Each high phase and each low phase of the serial clock lasts exactly HALF_DIV system cycles. The select falls at the start of the first low phase and rises on the falling edge that ends the 16th bit, 2·HALF_DIV·16 cycles after the request is accepted.
- R5: Between two frames the select lines stay high for at least CS_GAP_CYC system cycles.
- R6: When req_defer is 1 (deferred mode), the load strobe stays high throughout the frame. It falls LDAC_SETUP_CYC cycles after the select rises and stays low for LDAC_PULSE_CYC cycles.
- R7: When req_defer is 0 (immediate mode), the load strobe is low from the first frame cycle until the select-high interval after the frame has ended. It is therefore low when the select rises.
- R8: A code of CODE_W bits is placed in frame bits 15 down to 16-CODE_W. The remaining low bits are sent as 0.
- R9: req_ready is high when the block is idle. It stays low from the cycle after acceptance until the last interval (the select-high gap, which follows the load pulse in deferred mode) has elapsed.
- R10: A request with an address of NUM_CH or more is accepted. It lowers no select line and produces no serial clock. addr_err is high for one cycle, in the cycle after acceptance.
- R11: After reset, every select line and the load strobe are high, the serial clock and the data line are low, addr_err is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | ADDR_W | Target channel index |
| req_code | input | CODE_W | Conversion code, left-justified into the frame |
| req_defer | input | 1 | 1: deferred load strobe, 0: update on select rise |
| sclk | output | 1 | Shared serial clock, burst only |
| sdo | output | 1 | Shared serial data |
| cs_n | output | NUM_CH | One-hot active-low selects |
| ldac_n | output | 1 | Active-low load strobe, common to all channels |
| addr_err | output | 1 | One-cycle pulse on an out-of-range request |

## Verification
The bench watches every serial-clock phase and checks its length, so a divider that is off by one in either phase shows up as a wrong run length or a wrong select-rise cycle. Deferred and immediate writes are each checked cycle by cycle. A load strobe that is released too early, or that falls before its setup gap has elapsed, changes the measured fall and rise cycles. Two writes are sent back to back to measure the select-high gap, which a sequencer that skipped its gap state would shorten. The bench also sends out-of-range addresses, all-ones and all-zeros codes, and alternating-bit codes. A faulty decoder or shifter would then assert a select, toggle the clock, drop the zero padding or send the bits in the wrong order.

// File: rtl/mdac_pkg.sv
package mdac_pkg;
   localparam int FRAME_W = 16;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_SHIFT,
      SQ_LSETUP,
      SQ_LPULSE,
      SQ_GAP
   } seq_state_e;
endpackage

// File: rtl/mdac_cs_decode.sv
module mdac_cs_decode #(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 3
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [NUM_CH-1:0] sel_oh_o,
   output logic              in_range_o
);
   if (NUM_CH < 1 || NUM_CH > (1 << ADDR_W)) begin : g_bad_cfg
      $error("mdac_cs_decode: NUM_CH must lie in 1..2**ADDR_W");
   end

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_sel
      assign sel_oh_o[ch] = (addr_i == ADDR_W'(ch));
   end

   assign in_range_o = |sel_oh_o;
endmodule

// File: rtl/mdac_frame_shifter.sv
module mdac_frame_shifter
   import mdac_pkg::*;
#(
   parameter int HALF_DIV = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [FRAME_W-1:0] frame_i,
   output logic               sclk_o,
   output logic               sdo_o,
   output logic               busy_o,
   output logic               last_o
);
   localparam int HCNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam int BCNT_W = $clog2(FRAME_W);
   localparam logic [HCNT_W-1:0] HCNT_END = HCNT_W'(HALF_DIV - 1);
   localparam logic [BCNT_W-1:0] BCNT_END = BCNT_W'(FRAME_W - 1);

   if (HALF_DIV < 1) begin : g_bad_div
      $error("mdac_frame_shifter: HALF_DIV must be at least 1");
   end

   logic               busy_q;
   logic               sclk_q;
   logic [FRAME_W-1:0] shreg_q;
   logic [HCNT_W-1:0]  hcnt_q;
   logic [BCNT_W-1:0]  bcnt_q;
   logic               phase_end;

   assign phase_end = busy_q && (hcnt_q == HCNT_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         sclk_q  <= 1'b0;
         shreg_q <= '0;
         hcnt_q  <= '0;
         bcnt_q  <= '0;
      end else if (start_i && !busy_q) begin
         busy_q  <= 1'b1;
         sclk_q  <= 1'b0;
         shreg_q <= frame_i;
         hcnt_q  <= '0;
         bcnt_q  <= '0;
      end else if (busy_q) begin
         if (phase_end) begin
            hcnt_q <= '0;
            if (!sclk_q) begin
               sclk_q <= 1'b1;
            end else begin
               sclk_q <= 1'b0;
               if (bcnt_q == BCNT_END) begin
                  busy_q <= 1'b0;
               end else begin
                  bcnt_q  <= bcnt_q + 1'b1;
                  shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
               end
            end
         end else begin
            hcnt_q <= hcnt_q + 1'b1;
         end
      end
   end

   assign sclk_o = sclk_q;
   assign sdo_o  = busy_q & shreg_q[FRAME_W-1];
   assign busy_o = busy_q;
   assign last_o = phase_end && sclk_q && (bcnt_q == BCNT_END);

   // R2
   sdo_stable_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk_q) |-> $stable(sdo_o));

   // R3
   sclk_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |=> !sclk_q || busy_q);
endmodule

// File: rtl/mdac_seq.sv
module mdac_seq
   import mdac_pkg::*;
#(
   parameter int NUM_CH         = 4,
   parameter int CS_GAP_CYC     = 2,
   parameter int LDAC_SETUP_CYC = 1,
   parameter int LDAC_PULSE_CYC = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid_i,
   input  logic              req_defer_i,
   input  logic [NUM_CH-1:0] sel_oh_i,
   input  logic              in_range_i,
   input  logic              shift_last_i,
   output logic              req_ready_o,
   output logic              start_o,
   output logic [NUM_CH-1:0] cs_n_o,
   output logic              ldac_n_o,
   output logic              addr_err_o
);
   localparam int MAX_SL   = (LDAC_SETUP_CYC > LDAC_PULSE_CYC) ? LDAC_SETUP_CYC : LDAC_PULSE_CYC;
   localparam int MAX_WAIT = (MAX_SL > CS_GAP_CYC) ? MAX_SL : CS_GAP_CYC;
   localparam int CNT_W    = $clog2(MAX_WAIT + 1);
   localparam logic [CNT_W-1:0] GAP_END   = CNT_W'(CS_GAP_CYC - 1);
   localparam logic [CNT_W-1:0] SETUP_END = CNT_W'(LDAC_SETUP_CYC - 1);
   localparam logic [CNT_W-1:0] PULSE_END = CNT_W'(LDAC_PULSE_CYC - 1);

   if (CS_GAP_CYC < 1 || LDAC_SETUP_CYC < 1 || LDAC_PULSE_CYC < 1) begin : g_bad_cfg
      $error("mdac_seq: every interval must be at least one cycle");
   end

   seq_state_e        state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [NUM_CH-1:0] cs_n_q;
   logic              ldac_n_q;
   logic              defer_q;
   logic              err_q;
   logic              accept;

   assign req_ready_o = (state_q == SQ_IDLE);
   assign accept      = req_valid_i && req_ready_o;
   assign start_o     = accept && in_range_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SQ_IDLE;
         cnt_q    <= '0;
         cs_n_q   <= '1;
         ldac_n_q <= 1'b1;
         defer_q  <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         err_q <= accept && !in_range_i;
         case (state_q)
            SQ_IDLE: begin
               if (start_o) begin
                  state_q  <= SQ_SHIFT;
                  cs_n_q   <= ~sel_oh_i;
                  defer_q  <= req_defer_i;
                  ldac_n_q <= req_defer_i;
                  cnt_q    <= '0;
               end
            end
            SQ_SHIFT: begin
               if (shift_last_i) begin
                  cs_n_q  <= '1;
                  cnt_q   <= '0;
                  state_q <= defer_q ? SQ_LSETUP : SQ_GAP;
               end
            end
            SQ_LSETUP: begin
               if (cnt_q == SETUP_END) begin
                  cnt_q    <= '0;
                  ldac_n_q <= 1'b0;
                  state_q  <= SQ_LPULSE;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            SQ_LPULSE: begin
               if (cnt_q == PULSE_END) begin
                  cnt_q    <= '0;
                  ldac_n_q <= 1'b1;
                  state_q  <= SQ_GAP;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            SQ_GAP: begin
               if (cnt_q == GAP_END) begin
                  cnt_q    <= '0;
                  ldac_n_q <= 1'b1;
                  state_q  <= SQ_IDLE;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign cs_n_o     = cs_n_q;
   assign ldac_n_o   = ldac_n_q;
   assign addr_err_o = err_q;

   // R1
   cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n_q));

   // R6
   ldac_hold_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(&cs_n_q) && defer_q) |-> ldac_n_q);

   // R9
   ready_low_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(&cs_n_q) |-> !req_ready_o);

   // R10
   err_no_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> (&cs_n_q));

   // R5
   gap_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(&cs_n_q) |=> (&cs_n_q));
endmodule

// File: rtl/mdac_wr_ctrl.sv
module mdac_wr_ctrl
   import mdac_pkg::*;
#(
   parameter int NUM_CH         = 4,
   parameter int ADDR_W         = 3,
   parameter int CODE_W         = 12,
   parameter int HALF_DIV       = 2,
   parameter int CS_GAP_CYC     = 2,
   parameter int LDAC_SETUP_CYC = 1,
   parameter int LDAC_PULSE_CYC = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [CODE_W-1:0] req_code,
   input  logic              req_defer,
   output logic              sclk,
   output logic              sdo,
   output logic [NUM_CH-1:0] cs_n,
   output logic              ldac_n,
   output logic              addr_err
);
   localparam int PAD_W = FRAME_W - CODE_W;

   if (CODE_W < 1 || CODE_W > FRAME_W) begin : g_bad_code
      $error("mdac_wr_ctrl: CODE_W must lie in 1..16");
   end

   logic [FRAME_W-1:0] frame;
   logic [NUM_CH-1:0]  sel_oh;
   logic               in_range;
   logic               start;
   logic               busy;
   logic               last;

   if (PAD_W == 0) begin : g_full
      assign frame = req_code;
   end else begin : g_pad
      assign frame = {req_code, {PAD_W{1'b0}}};
   end

   mdac_cs_decode #(
      .NUM_CH (NUM_CH),
      .ADDR_W (ADDR_W)
   ) dec_i (
      .addr_i     (req_addr),
      .sel_oh_o   (sel_oh),
      .in_range_o (in_range)
   );

   mdac_frame_shifter #(
      .HALF_DIV (HALF_DIV)
   ) shf_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .frame_i (frame),
      .sclk_o  (sclk),
      .sdo_o   (sdo),
      .busy_o  (busy),
      .last_o  (last)
   );

   mdac_seq #(
      .NUM_CH         (NUM_CH),
      .CS_GAP_CYC     (CS_GAP_CYC),
      .LDAC_SETUP_CYC (LDAC_SETUP_CYC),
      .LDAC_PULSE_CYC (LDAC_PULSE_CYC)
   ) seq_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid_i  (req_valid),
      .req_defer_i  (req_defer),
      .sel_oh_i     (sel_oh),
      .in_range_i   (in_range),
      .shift_last_i (last),
      .req_ready_o  (req_ready),
      .start_o      (start),
      .cs_n_o       (cs_n),
      .ldac_n_o     (ldac_n),
      .addr_err_o   (addr_err)
   );

   // R3
   sclk_quiet_unselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&cs_n) |-> !sclk);

   // R1
   busy_matches_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !(&cs_n));
endmodule

// File: tb/mdac_wr_ctrl_tb_top.sv
module mdac_wr_ctrl_tb_top;
   localparam int NUM_CH = 4;
   localparam int ADDR_W = 3;
   localparam int CODE_W = 12;
   localparam int H      = 2;
   localparam int G      = 2;
   localparam int S      = 1;
   localparam int P      = 1;
   localparam int EXP_RISE = 2 * H * 16 + 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [CODE_W-1:0] req_code = '0;
   logic              req_defer = 1'b0;
   logic              sclk;
   logic              sdo;
   logic [NUM_CH-1:0] cs_n;
   logic              ldac_n;
   logic              addr_err;

   int n_chk = 0;
   int n_err = 0;

   int obs_word, obs_bits, obs_cs_bad, obs_run_bad, obs_idle_sclk;
   int obs_rise, obs_ldac_at_rise, obs_lfall, obs_lrise, obs_ldac_frame_bad;
   int obs_ready1, obs_ready_idx;

   always #10 clk = ~clk;

   mdac_wr_ctrl #(
      .NUM_CH (NUM_CH), .ADDR_W (ADDR_W), .CODE_W (CODE_W), .HALF_DIV (H),
      .CS_GAP_CYC (G), .LDAC_SETUP_CYC (S), .LDAC_PULSE_CYC (P)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
      .req_addr (req_addr), .req_code (req_code), .req_defer (req_defer),
      .sclk (sclk), .sdo (sdo), .cs_n (cs_n), .ldac_n (ldac_n), .addr_err (addr_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   // Issue one in-range request at a negedge and watch it until ready returns.
   task automatic send_and_watch(input int addr, input logic [CODE_W-1:0] code, input logic defer);
      int idx;
      logic prev_sclk, prev_csall, prev_ldac, csall;
      int lastchg;
      obs_word = 0; obs_bits = 0; obs_cs_bad = 0; obs_run_bad = 0; obs_idle_sclk = 0;
      obs_rise = -1; obs_ldac_at_rise = -1; obs_lfall = -1; obs_lrise = -1;
      obs_ldac_frame_bad = 0; obs_ready_idx = -1;
      chk(req_ready == 1'b1, "R9 ready before request", int'(req_ready), 1);
      req_valid = 1'b1; req_addr = ADDR_W'(addr); req_code = code; req_defer = defer;
      prev_sclk = sclk; prev_csall = &cs_n; prev_ldac = ldac_n; lastchg = 1;
      @(negedge clk);
      req_valid = 1'b0;
      idx = 1;
      obs_ready1 = int'(req_ready);
      for (int guard = 0; guard < 1000; guard++) begin
         csall = &cs_n;
         if (!csall && cs_n != ~(NUM_CH'(1) << addr)) obs_cs_bad++;
         if (!csall && defer && !ldac_n) obs_ldac_frame_bad++;
         if (csall && sclk) obs_idle_sclk++;
         if (sclk != prev_sclk) begin
            if (idx - lastchg != H) obs_run_bad++;
            lastchg = idx;
            if (sclk) begin
               obs_word = ((obs_word << 1) | int'(sdo)) & 16'hFFFF;
               obs_bits++;
            end
         end
         if (csall && !prev_csall) begin
            obs_rise = idx;
            obs_ldac_at_rise = int'(ldac_n);
         end
         if (prev_ldac && !ldac_n) obs_lfall = idx;
         if (!prev_ldac && ldac_n) obs_lrise = idx;
         prev_sclk = sclk; prev_csall = csall; prev_ldac = ldac_n;
         if (idx > 1 && req_ready) begin
            obs_ready_idx = idx;
            break;
         end
         @(negedge clk);
         idx++;
      end
   endtask

   task automatic verify_txn(input int exp_word, input logic defer);
      chk(obs_ready1 == 0, "R9 ready low after accept", obs_ready1, 0);
      chk(obs_bits == 16, "R2 rising edges per frame", obs_bits, 16);
      chk(obs_word == exp_word, "R2 R8 frame content", obs_word, exp_word);
      chk(obs_cs_bad == 0, "R1 select decode", obs_cs_bad, 0);
      chk(obs_run_bad == 0, "R4 clock phase length", obs_run_bad, 0);
      chk(obs_idle_sclk == 0, "R3 clock while unselected", obs_idle_sclk, 0);
      chk(obs_rise == EXP_RISE, "R4 select rise cycle", obs_rise, EXP_RISE);
      if (defer) begin
         chk(obs_ldac_frame_bad == 0, "R6 strobe high in frame", obs_ldac_frame_bad, 0);
         chk(obs_lfall == obs_rise + S, "R6 strobe setup", obs_lfall, obs_rise + S);
         chk(obs_lrise == obs_lfall + P, "R6 strobe width", obs_lrise, obs_lfall + P);
         chk(obs_ready_idx == obs_lrise + G, "R9 ready after gap", obs_ready_idx, obs_lrise + G);
      end else begin
         chk(obs_ldac_at_rise == 0, "R7 strobe low at select rise", obs_ldac_at_rise, 0);
         chk(obs_lrise == obs_ready_idx, "R7 strobe held through gap", obs_lrise, obs_ready_idx);
         chk(obs_ready_idx == obs_rise + G, "R9 ready after gap", obs_ready_idx, obs_rise + G);
      end
   endtask

   task automatic t_reset();
      chk(cs_n == '1, "R11 selects high", int'(cs_n), (1 << NUM_CH) - 1);
      chk(ldac_n == 1'b1, "R11 strobe high", int'(ldac_n), 1);
      chk(sclk == 1'b0 && sdo == 1'b0, "R11 clock and data low", int'({sclk, sdo}), 0);
      chk(addr_err == 1'b0, "R11 error low", int'(addr_err), 0);
      chk(req_ready == 1'b1, "R11 ready high", int'(req_ready), 1);
   endtask

   task automatic t_immediate();
      send_and_watch(0, 12'hABC, 1'b0);
      verify_txn(16'hABC0, 1'b0);
   endtask

   task automatic t_deferred();
      send_and_watch(3, 12'h801, 1'b1);
      verify_txn(16'h8010, 1'b1);
   endtask

   task automatic t_patterns();
      send_and_watch(1, 12'hFFF, 1'b0);
      verify_txn(16'hFFF0, 1'b0); // R8 padding zeros after all-ones code
      send_and_watch(2, 12'h000, 1'b1);
      verify_txn(16'h0000, 1'b1);
      send_and_watch(2, 12'h555, 1'b0);
      verify_txn(16'h5550, 1'b0);
   endtask

   task automatic t_back_to_back();
      int gap;
      send_and_watch(1, 12'h3C3, 1'b0);
      verify_txn(16'h3C30, 1'b0);
      gap = obs_ready_idx - obs_rise + 1;
      chk(gap >= G, "R5 select-high gap", gap, G);
      send_and_watch(2, 12'hC3C, 1'b1);
      chk(cs_n == '1, "R5 selects high at end", int'(cs_n), (1 << NUM_CH) - 1);
      verify_txn(16'hC3C0, 1'b1);
   endtask

   task automatic t_bad_addr();
      int sclk_seen;
      int cs_seen;
      chk(req_ready == 1'b1, "R10 ready before bad request", int'(req_ready), 1);
      req_valid = 1'b1; req_addr = ADDR_W'(5); req_code = 12'h123; req_defer = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      chk(addr_err == 1'b1, "R10 error pulse", int'(addr_err), 1);
      chk(cs_n == '1, "R10 no select", int'(cs_n), (1 << NUM_CH) - 1);
      @(negedge clk);
      chk(addr_err == 1'b0, "R10 error one cycle", int'(addr_err), 0);
      sclk_seen = 0; cs_seen = 0;
      for (int k = 0; k < 20; k++) begin
         if (sclk) sclk_seen++;
         if (cs_n != '1 || !ldac_n) cs_seen++;
         @(negedge clk);
      end
      chk(sclk_seen == 0, "R10 no clock", sclk_seen, 0);
      chk(cs_seen == 0, "R10 no select or strobe", cs_seen, 0);
      send_and_watch(3, 12'h0F0, 1'b0);
      verify_txn(16'h0F00, 1'b0);
   endtask

   initial begin
      #(20 * 150000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_immediate();
      t_deferred();
      t_patterns();
      t_back_to_back();
      t_bad_addr();
      repeat (4) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule